// File: doc/BRIEF.md
# I2C Target Address and Acknowledge Engine

This block sits behind the SCL and SDA pads of an I2C target. It brings both lines into the system clock domain and finds start and stop conditions. After every start it shifts in the first byte as a 7-bit address followed by a direction bit, and compares that address with a programmable own address. It returns the acknowledge by asking the pad to pull SDA low during the ninth clock. Once the target is addressed for writing, it keeps taking in data bytes, shows each one with a single-cycle strobe, and decides the acknowledge for each byte from a software enable.

Software selects where the bus is stretched: right after the eighth clock or right after the ninth. With the eight-clock setting, SCL is held low before the acknowledge slot. The value of the enable when software releases the wait decides ACK or NACK for that byte. With the nine-clock setting, the acknowledge follows from the enable as it stands at the eighth falling edge, and the hold comes after the ninth clock. A matching address is always acknowledged, whatever the enable says. A withheld acknowledge ends the transfer: the block then ignores the bus until the next start.

Top module: `i2c_tgt_ack_ctrl`

## Requirements
- R1: After reset, sda_drive_low_o, scl_hold_o, rx_valid_o, addr_match_o and dir_tx_o are all 0.
- R2: When the seven address bits (first byte after a start, MSB first) equal own_addr_i, sda_drive_low_o is 1 through the ninth SCL clock whatever ack_en_i is, and addr_match_o becomes 1.
- R3: When the address differs from own_addr_i, SDA is not pulled in the ninth clock, addr_match_o stays 0, and later bytes give neither ACK nor rx_valid_o until the next start.
- R4: The eighth bit of the address byte sets dir_tx_o (1 = target transmits, 0 = target receives). When it is 1, clocks after the address acknowledge produce neither rx_valid_o nor ACK.
- R5: Each data byte received while addressed with dir_tx_o = 0 appears on rx_data_o (first bit received in bit 7), with a one-cycle rx_valid_o pulse after its eighth falling SCL edge. rx_data_o holds its value until the next byte.
- R6: With wait9_i = 1, a data byte is acknowledged exactly when ack_en_i is 1 at its eighth falling edge, and SCL is not held between the eighth and the ninth clock.
- R7: With wait9_i = 1, scl_hold_o rises after the ninth falling edge of every acknowledged byte (matching address or data). It stays 1 until a wait_release_i pulse.
- R8: With wait9_i = 0, scl_hold_o rises after the eighth falling edge of each data byte with SDA still released. At the wait_release_i pulse the hold drops, and SDA is pulled exactly when ack_en_i is 1 in that same cycle. Any pull starts while SCL is still low.
- R9: The SDA pull of an acknowledge ends after the ninth falling edge, before the next bit.
- R10: After a NACK on a data byte, further bytes are neither acknowledged nor reported until a start.
- R11: A start (SDA falls while SCL is high) restarts address reception even in the middle of a byte. A stop (SDA rises while SCL is high) returns the block to idle and clears addr_match_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL pad level |
| sda_i | input | 1 | SDA pad level |
| own_addr_i | input | ADDR_W | Address this target answers to |
| ack_en_i | input | 1 | Acknowledge enable for data bytes |
| wait9_i | input | 1 | 1: stretch after the ninth clock; 0: after the eighth |
| wait_release_i | input | 1 | One-cycle strobe that ends a clock stretch |
| sda_drive_low_o | output | 1 | Pull SDA low (open-drain request) |
| scl_hold_o | output | 1 | Pull SCL low (stretch request) |
| rx_data_o | output | ADDR_W+1 | Last received data byte |
| rx_valid_o | output | 1 | One-cycle strobe: new byte on rx_data_o |
| dir_tx_o | output | 1 | Direction bit of the current address |
| addr_match_o | output | 1 | Target addressed since the last start |

## Verification
In the eight-clock mode, software may write the acknowledge enable and give the wait release in the same system-clock cycle. The block must then act on the new enable value, not on the old one. The bench provokes this by changing ack_en_i in the same cycle as the release strobe, once from 0 to 1 and once from 1 to 0. It then checks that the SDA pull appears, or stays absent, while SCL is still held low, and that the controller samples the matching ACK or NACK at the ninth rising edge. A repeated start placed inside a half-received byte is also checked, to show that the start takes priority over a bit count in progress.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   // Receive engine phases
   typedef enum logic [2:0] {
      ST_IDLE,   // not addressed, or transfer ended: wait for start
      ST_SHIFT,  // collecting the eight bits of a byte
      ST_WAIT8,  // SCL stretched after eighth clock, ACK undecided
      ST_ACK,    // SDA pulled low for the ninth clock
      ST_WAIT9   // SCL stretched after ninth clock
   } tgt_state_e;

endpackage

// File: rtl/i2c_tgt_line_sync.sv
module i2c_tgt_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic lvl_o,
   output logic prev_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_tgt_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   // idle bus level is high, so flops come out of reset at 1
   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b1;
            else        chain[0] <= line_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= 1'b1;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_o <= 1'b1;
      else        prev_o <= chain[STAGES-1];
   end

   assign lvl_o = chain[STAGES-1];

endmodule

// File: rtl/i2c_tgt_shifter.sv
module i2c_tgt_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         take_i,
   input  logic         bit_i,
   output logic [W-1:0] data_o,
   output logic         full_o
);

   localparam int CW = $clog2(W + 1);
   localparam logic [CW-1:0] FULL = CW'(W);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         data_o <= '0;
      end else if (clr_i) begin
         cnt <= '0;
      end else if (take_i && (cnt != FULL)) begin
         cnt    <= cnt + 1'b1;
         data_o <= {data_o[W-2:0], bit_i};
      end
   end

   assign full_o = (cnt == FULL);

endmodule

// File: rtl/i2c_tgt_ack_fsm.sv
module i2c_tgt_ack_fsm
   import i2c_tgt_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              scl_fall_i,
   input  logic              full_i,
   input  logic [ADDR_W:0]   shreg_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic              ack_en_i,
   input  logic              wait9_i,
   input  logic              release_i,
   output logic              shift_en_o,
   output logic              sda_low_o,
   output logic              hold_o,
   output logic              valid_o,
   output logic [ADDR_W:0]   data_o,
   output logic              match_o,
   output logic              dir_o
);

   tgt_state_e state;
   tgt_state_e resume;
   logic       is_addr;
   logic       hit;

   assign hit        = (shreg_i[ADDR_W:1] == own_addr_i);
   assign resume     = dir_o ? ST_IDLE : ST_SHIFT;
   assign shift_en_o = (state == ST_SHIFT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         is_addr   <= 1'b1;
         match_o   <= 1'b0;
         dir_o     <= 1'b0;
         sda_low_o <= 1'b0;
         hold_o    <= 1'b0;
         valid_o   <= 1'b0;
         data_o    <= '0;
      end else begin
         valid_o <= 1'b0;
         if (start_i) begin
            state     <= ST_SHIFT;
            is_addr   <= 1'b1;
            match_o   <= 1'b0;
            dir_o     <= 1'b0;
            sda_low_o <= 1'b0;
            hold_o    <= 1'b0;
         end else if (stop_i) begin
            state     <= ST_IDLE;
            match_o   <= 1'b0;
            dir_o     <= 1'b0;
            sda_low_o <= 1'b0;
            hold_o    <= 1'b0;
         end else begin
            case (state)
               ST_SHIFT: if (scl_fall_i && full_i) begin
                  if (is_addr) begin
                     if (hit) begin
                        match_o   <= 1'b1;
                        dir_o     <= shreg_i[0];
                        sda_low_o <= 1'b1;
                        state     <= ST_ACK;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else begin
                     data_o  <= shreg_i;
                     valid_o <= 1'b1;
                     if (!wait9_i) begin
                        hold_o <= 1'b1;
                        state  <= ST_WAIT8;
                     end else if (ack_en_i) begin
                        sda_low_o <= 1'b1;
                        state     <= ST_ACK;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               ST_WAIT8: if (release_i) begin
                  hold_o <= 1'b0;
                  if (ack_en_i) begin
                     sda_low_o <= 1'b1;
                     state     <= ST_ACK;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
               ST_ACK: if (scl_fall_i) begin
                  sda_low_o <= 1'b0;
                  is_addr   <= 1'b0;
                  if (wait9_i) begin
                     hold_o <= 1'b1;
                     state  <= ST_WAIT9;
                  end else begin
                     state <= resume;
                  end
               end
               ST_WAIT9: if (release_i) begin
                  hold_o <= 1'b0;
                  state  <= resume;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/i2c_tgt_ack_ctrl.sv
module i2c_tgt_ack_ctrl #(
   parameter int ADDR_W      = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic              ack_en_i,
   input  logic              wait9_i,
   input  logic              wait_release_i,
   output logic              sda_drive_low_o,
   output logic              scl_hold_o,
   output logic [ADDR_W:0]   rx_data_o,
   output logic              rx_valid_o,
   output logic              dir_tx_o,
   output logic              addr_match_o
);

   localparam int BYTE_W = ADDR_W + 1;

   if (ADDR_W < 1) begin : g_bad_addr
      $error("i2c_tgt_ack_ctrl: ADDR_W must be positive");
   end

   logic scl_lvl, scl_prev, sda_lvl, sda_prev;
   logic scl_rise, scl_fall, start_det, stop_det;
   logic shift_en, full;
   logic [BYTE_W-1:0] shreg;

   i2c_tgt_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .line_i(scl_i), .lvl_o(scl_lvl), .prev_o(scl_prev));

   i2c_tgt_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .line_i(sda_i), .lvl_o(sda_lvl), .prev_o(sda_prev));

   assign scl_rise  =  scl_lvl & ~scl_prev;
   assign scl_fall  = ~scl_lvl &  scl_prev;
   assign start_det =  scl_lvl &  scl_prev &  sda_prev & ~sda_lvl;
   assign stop_det  =  scl_lvl &  scl_prev & ~sda_prev &  sda_lvl;

   i2c_tgt_shifter #(.W(BYTE_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .clr_i(start_det | ~shift_en),
      .take_i(shift_en & scl_rise),
      .bit_i(sda_lvl),
      .data_o(shreg), .full_o(full));

   i2c_tgt_ack_fsm #(.ADDR_W(ADDR_W)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .start_i(start_det), .stop_i(stop_det), .scl_fall_i(scl_fall),
      .full_i(full), .shreg_i(shreg), .own_addr_i(own_addr_i),
      .ack_en_i(ack_en_i), .wait9_i(wait9_i), .release_i(wait_release_i),
      .shift_en_o(shift_en), .sda_low_o(sda_drive_low_o), .hold_o(scl_hold_o),
      .valid_o(rx_valid_o), .data_o(rx_data_o),
      .match_o(addr_match_o), .dir_o(dir_tx_o));

endmodule

// File: rtl/i2c_tgt_ack_chk.sv
module i2c_tgt_ack_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_drive_low_o,
   input logic              scl_hold_o,
   input logic [DATA_W-1:0] rx_data_o,
   input logic              rx_valid_o,
   input logic              dir_tx_o,
   input logic              addr_match_o
);

   // R8: a new SDA pull only ever begins while SCL is low
   a_r8_pull_starts_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_drive_low_o) |-> !scl_i);

   // R9: the stretch and the acknowledge pull never overlap
   a_r9_hold_pull_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(scl_hold_o && sda_drive_low_o));

   // R5: byte strobe lasts one cycle
   a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |=> !rx_valid_o);

   // R5: received byte changes only together with its strobe
   a_r5_data_held: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid_o |=> ($stable(rx_data_o) || rx_valid_o));

   // R3: no acknowledge is ever driven unless addressed
   a_r3_pull_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
      sda_drive_low_o |-> addr_match_o);

   // R7: stretching only happens once addressed
   a_r7_hold_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
      scl_hold_o |-> addr_match_o);

   // R4: in transmit direction no bytes are reported
   a_r4_tx_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
      dir_tx_o |-> !rx_valid_o);

endmodule

bind i2c_tgt_ack_ctrl i2c_tgt_ack_chk #(.DATA_W(ADDR_W + 1)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i),
   .sda_drive_low_o(sda_drive_low_o), .scl_hold_o(scl_hold_o),
   .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
   .dir_tx_o(dir_tx_o), .addr_match_o(addr_match_o));

// File: tb/i2c_tgt_ack_ctrl_tb.sv
`timescale 1ns/1ps
module i2c_tgt_ack_ctrl_tb;

   localparam logic [6:0] OWN = 7'h5A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic ack_en = 1'b0, wait9 = 1'b1, rel = 1'b0;
   logic sda_drive_low_o, scl_hold_o, rx_valid_o, dir_tx_o, addr_match_o;
   logic [7:0] rx_data_o;
   wire  scl_line = scl_m & ~scl_hold_o;
   wire  sda_line = sda_m & ~sda_drive_low_o;

   int n_chk = 0, n_fail = 0, vcnt = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   i2c_tgt_ack_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .own_addr_i(OWN), .ack_en_i(ack_en), .wait9_i(wait9), .wait_release_i(rel),
      .sda_drive_low_o(sda_drive_low_o), .scl_hold_o(scl_hold_o),
      .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
      .dir_tx_o(dir_tx_o), .addr_match_o(addr_match_o));

   always @(posedge clk) if (rx_valid_o === 1'b1) vcnt <= vcnt + 1;

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic put_bit(input logic b);
      sda_m = b; tick(5);
      scl_m = 1'b1; tick(10);
      scl_m = 1'b0; tick(5);
   endtask

   task automatic put_bits(input logic [7:0] v, input int n);
      for (int i = 7; i > 7 - n; i--) put_bit(v[i]);
   endtask

   // ninth clock; acked = SDA seen low while SCL is high
   task automatic ninth(output logic acked);
      sda_m = 1'b1; tick(5);
      scl_m = 1'b1;
      wait (scl_line === 1'b1);
      tick(5);
      acked = ~sda_line;
      tick(5);
      scl_m = 1'b0; tick(6);
   endtask

   task automatic start_c();
      sda_m = 1'b1; tick(3);
      scl_m = 1'b1; tick(6);
      sda_m = 1'b0; tick(6);
      scl_m = 1'b0; tick(4);
   endtask

   task automatic stop_c();
      sda_m = 1'b0; tick(3);
      scl_m = 1'b1; tick(6);
      sda_m = 1'b1; tick(6);
   endtask

   task automatic pulse_rel();
      rel = 1'b1; tick(1);
      rel = 1'b0; tick(2);
   endtask

   task automatic t_reset();
      chk("R1 sda pull", sda_drive_low_o, 0);
      chk("R1 scl hold", scl_hold_o, 0);
      chk("R1 valid", rx_valid_o, 0);
      chk("R1 match", addr_match_o, 0);
      chk("R1 dir", dir_tx_o, 0);
   endtask

   // wait9, enable off: address still acked, data NACKed, rest ignored
   task automatic t_match_no_enable();
      logic a; int v0;
      wait9 = 1'b1; ack_en = 1'b0;
      start_c();
      put_bits({OWN, 1'b0}, 8); ninth(a);
      chk("R2 address ack with enable off", a, 1);
      chk("R2 match flag", addr_match_o, 1);
      chk("R4 dir receive", dir_tx_o, 0);
      chk("R7 hold after ninth", scl_hold_o, 1);
      chk("R9 pull released", sda_drive_low_o, 0);
      tick(20);
      chk("R7 hold persists", scl_hold_o, 1);
      pulse_rel();
      chk("R7 hold released", scl_hold_o, 0);
      v0 = vcnt;
      put_bits(8'hC3, 8);
      chk("R6 no hold before ninth", scl_hold_o, 0);
      chk("R5 strobe count", vcnt - v0, 1);
      chk("R5 byte value", rx_data_o, 8'hC3);
      ninth(a);
      chk("R6 nack with enable off", a, 0);
      chk("R6 no hold after nack", scl_hold_o, 0);
      put_bits(8'h11, 8); ninth(a);
      chk("R10 ignored after nack ack", a, 0);
      chk("R10 ignored after nack strobe", vcnt - v0, 1);
      stop_c();
      chk("R11 stop clears match", addr_match_o, 0);
   endtask

   task automatic t_mismatch();
      logic a; int v0;
      wait9 = 1'b1; ack_en = 1'b1;
      start_c();
      put_bits({7'h33, 1'b0}, 8); ninth(a);
      chk("R3 no ack on other address", a, 0);
      chk("R3 match flag low", addr_match_o, 0);
      v0 = vcnt;
      put_bits(8'hF0, 8); ninth(a);
      chk("R3 data ignored ack", a, 0);
      chk("R3 data ignored strobe", vcnt - v0, 0);
      chk("R3 no hold", scl_hold_o, 0);
      stop_c();
   endtask

   task automatic t_wait9_ack();
      logic a; int v0;
      wait9 = 1'b1; ack_en = 1'b1;
      start_c();
      put_bits({OWN, 1'b0}, 8); ninth(a);
      pulse_rel();
      v0 = vcnt;
      put_bits(8'hA5, 8); ninth(a);
      chk("R6 ack with enable on", a, 1);
      chk("R7 hold after data ack", scl_hold_o, 1);
      chk("R9 pull released after ninth", sda_drive_low_o, 0);
      chk("R5 byte A5", rx_data_o, 8'hA5);
      pulse_rel();
      put_bits(8'h5A, 8); ninth(a);
      chk("R6 second ack", a, 1);
      chk("R5 byte 5A", rx_data_o, 8'h5A);
      chk("R5 two strobes", vcnt - v0, 2);
      pulse_rel();
      stop_c();
   endtask

   // wait8: enable written in the same cycle as the release
   task automatic t_wait8();
      logic a; int v0;
      wait9 = 1'b0; ack_en = 1'b0;
      start_c();
      put_bits({OWN, 1'b0}, 8); ninth(a);
      chk("R2 address ack wait8", a, 1);
      v0 = vcnt;
      put_bits(8'h3C, 8);
      chk("R8 hold after eighth", scl_hold_o, 1);
      chk("R8 sda free while held", sda_drive_low_o, 0);
      tick(30);
      chk("R8 hold persists", scl_hold_o, 1);
      ack_en = 1'b1; rel = 1'b1; tick(1);
      rel = 1'b0; tick(1);
      chk("R8 same-cycle enable gives pull", sda_drive_low_o, 1);
      chk("R8 hold dropped", scl_hold_o, 0);
      chk("R8 pull before ninth rise", scl_line, 0);
      ninth(a);
      chk("R8 ack seen", a, 1);
      chk("R9 released after ninth", sda_drive_low_o, 0);
      chk("R5 byte 3C", rx_data_o, 8'h3C);
      put_bits(8'h81, 8);
      chk("R8 hold second byte", scl_hold_o, 1);
      ack_en = 1'b0; rel = 1'b1; tick(1);
      rel = 1'b0; tick(1);
      chk("R8 same-cycle clear gives no pull", sda_drive_low_o, 0);
      ninth(a);
      chk("R8 nack seen", a, 0);
      put_bits(8'h7E, 8);
      chk("R10 no hold after nack", scl_hold_o, 0);
      ninth(a);
      chk("R10 no ack after nack", a, 0);
      chk("R10 strobes", vcnt - v0, 2);
      stop_c();
   endtask

   task automatic t_dir_tx();
      logic a; int v0;
      wait9 = 1'b0; ack_en = 1'b1;
      start_c();
      put_bits({OWN, 1'b1}, 8); ninth(a);
      chk("R4 address ack read", a, 1);
      chk("R4 dir transmit", dir_tx_o, 1);
      v0 = vcnt;
      put_bits(8'hFF, 8); ninth(a);
      chk("R4 no receive strobe", vcnt - v0, 0);
      chk("R4 no ack in transmit", a, 0);
      stop_c();
      chk("R11 stop clears dir", dir_tx_o, 0);
   endtask

   task automatic t_restart();
      logic a;
      wait9 = 1'b0; ack_en = 1'b0;
      start_c();
      put_bits(8'hFF, 4);
      start_c();
      put_bits({OWN, 1'b0}, 8); ninth(a);
      chk("R11 repeated start mid-byte", a, 1);
      chk("R11 match after restart", addr_match_o, 1);
      stop_c();
      chk("R11 stop returns idle", addr_match_o, 0);
   endtask

   initial begin
      tick(4);
      rst_n = 1'b1;
      tick(4);
      t_reset();
      t_match_no_enable();
      t_mismatch();
      t_wait9_ack();
      t_wait8();
      t_dir_tx();
      t_restart();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule